// File: doc/BRIEF.md
# Pipelined SPI Register Slave with Parity

This block lets an external host read and write a small register map over a four-wire serial link. The link runs in SPI mode 1: clock idle low, with input bits taken on the falling clock edge. Every frame is 16 bits long and is sent most significant bit first. SCLK, chip select and MOSI are slow asynchronous inputs. Each one passes through a two-flop synchroniser into the system clock domain, and an edge detector then finds its transitions. A command is carried out when chip select is released. Its result is shifted out on MISO during the following frame, so every response belongs to the frame before it.

Parity protects both directions of the link. Each response also carries a flag that reports whether the previous frame failed. Failures are recorded in a sticky three-bit error register, which returns to zero once it has been read. The address space outside the error register and the no-operation address is passed on through a simple register-file port. That port carries an address, a one-cycle write strobe and write data, and takes back read data and an address-valid indication.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset the MISO enable is low, no write strobe is issued, and the first frame returns 0x0000.
- R2: MISO is enabled only while the synchronised chip select is low. Writes to the register port happen only while MISO is disabled.
- R3: A command word holds even parity over bits 14:0 in bit 15, a read flag (1 = read, 0 = write) in bit 14, and the address in bits 13:0. A valid read of an external address returns that register's content during the next frame.
- R4: A command addressed to 0x0000 is a no-operation, and its response data is 0x0000.
- R5: A write is a command frame followed by a data frame. The data frame holds parity in bit 15, a 0 in bit 14 and the value in bits 13:0. The data frame returns the old content of the register. A valid data frame produces exactly one single-cycle write strobe with the saved address and the value. The next frame then returns the new content. Addresses 0x0000 and 0x0001 are never forwarded as writes.
- R6: A command frame with odd overall parity is not executed. It sets error bit 2, and the next response has bit 14 set and data 0.
- R7: A command frame to an address of 2 or above that the register port reports as invalid sets error bit 1. The next response has bit 14 set and data 0.
- R8: A frame that ends after any number of falling SCLK edges other than 16 is not executed. It sets error bit 0, and the next response has bit 14 set.
- R9: A read of address 0x0001 returns the error register (bit 2 parity, bit 1 invalid address, bit 0 framing) and then clears it to zero.
- R10: A write data frame with bad parity, or with bit 14 set, writes nothing. It sets error bit 2, and the next response has bit 14 set and data 0.
- R11: Every response word has even parity over all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low chip select from host |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | MISO drive enable; high-impedance when low |
| reg_addr_o | output | 14 | Register-file address |
| reg_we_o | output | 1 | Register-file write strobe, one cycle |
| reg_wdata_o | output | 14 | Register-file write data |
| reg_rdata_i | input | 14 | Register-file read data for reg_addr_o |
| reg_addr_ok_i | input | 1 | High when reg_addr_o names an existing register |

## Verification
A frame is carried out about six system cycles after chip select rises. Two of those cycles are synchronisation, then one cycle each for edge detection, classification, the write strobe and response capture. After each falling SCLK edge, the next MISO bit appears about three cycles later. The bench therefore keeps chip select high for twenty cycles between frames and samples MISO five cycles after each rising SCLK edge, well clear of both windows. A scoreboard holds the expected response of every frame, and that value is fixed by the frame before it. Write-strobe counts and values are checked only after chip select has been high long enough for the strobe to have occurred.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_ERRFL = 2'd1,
    SRC_EXT   = 2'd2
  } rsp_src_e;

  // bit 2 parity, bit 1 invalid address, bit 0 framing
  typedef struct packed {
    logic par_err;
    logic inv_err;
    logic frm_err;
  } err_flags_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {STAGES{RST_VAL[b]}};
      else         ff <= {ff[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff[STAGES-1];
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_fall_i,
  input  logic               cs_act_i,
  input  logic               sclk_fall_i,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic [FRAME_W-1:0] rx_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               miso_o
);

  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else if (cs_fall_i) begin
      tx_q  <= load_i;
      cnt_q <= '0;
    end else if (sclk_fall_i && cs_act_i) begin
      rx_q <= {rx_q[FRAME_W-2:0], mosi_i};
      // host has sampled current bit; present the next one
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rx_o   = rx_q;
  assign cnt_o  = cnt_q;
  assign miso_o = tx_q[FRAME_W-1];

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_rise_i,
  input  logic [FRAME_W-1:0] rx_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [FRAME_W-3:0] reg_addr_o,
  output logic               reg_we_o,
  output logic [FRAME_W-3:0] reg_wdata_o,
  input  logic [FRAME_W-3:0] reg_rdata_i,
  input  logic               reg_addr_ok_i,
  output logic [FRAME_W-1:0] resp_o
);

  localparam int unsigned DATA_W = FRAME_W - 2;
  localparam int unsigned RD_BIT = FRAME_W - 2;
  localparam logic [DATA_W-1:0] NOP_ADDR = DATA_W'(0);
  localparam logic [DATA_W-1:0] ERR_ADDR = DATA_W'(1);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] frame_q, resp_q;
  logic [DATA_W-1:0]  addr_q, wdata_q, rsp_data;
  logic               len_ok_q, wr_pend_q, v1_q, v2_q, v3_q, we_q, ef_q;
  err_flags_t         errfl_q, errsnap_q, err_now;
  rsp_src_e           src_q, src_d, src_addr;
  logic               clr_d, we_d, pend_d, par_ok, addr_int;

  assign par_ok   = ~^frame_q;
  assign addr_int = (addr_q == NOP_ADDR) || (addr_q == ERR_ADDR);
  assign src_addr = (addr_q == NOP_ADDR) ? SRC_ZERO :
                    (addr_q == ERR_ADDR) ? SRC_ERRFL : SRC_EXT;

  // classify the completed frame
  always_comb begin
    err_now = '0;
    src_d   = SRC_ZERO;
    clr_d   = 1'b0;
    we_d    = 1'b0;
    pend_d  = wr_pend_q;
    if (!len_ok_q) begin
      err_now.frm_err = 1'b1;
      pend_d          = 1'b0;
    end else if (wr_pend_q) begin
      pend_d = 1'b0;
      if (par_ok && !frame_q[RD_BIT]) begin
        we_d  = !addr_int;
        src_d = src_addr;
      end else begin
        err_now.par_err = 1'b1;
      end
    end else if (!par_ok) begin
      err_now.par_err = 1'b1;
    end else if (!addr_int && !reg_addr_ok_i) begin
      err_now.inv_err = 1'b1;
    end else begin
      src_d = src_addr;
      if (frame_q[RD_BIT]) clr_d  = (addr_q == ERR_ADDR);
      else                 pend_d = 1'b1;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ERRFL: rsp_data = {{(DATA_W-3){1'b0}}, errsnap_q};
      SRC_EXT:   rsp_data = reg_rdata_i;
      default:   rsp_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= '0;
      len_ok_q  <= 1'b0;
      addr_q    <= '0;
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      v3_q      <= 1'b0;
      wr_pend_q <= 1'b0;
      errfl_q   <= '0;
      errsnap_q <= '0;
      src_q     <= SRC_ZERO;
      ef_q      <= 1'b0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      resp_q    <= '0;
    end else begin
      v1_q <= cs_rise_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
      if (cs_rise_i) begin
        frame_q  <= rx_i;
        len_ok_q <= (cnt_i == FULL_CNT);
        if (!wr_pend_q && cnt_i == FULL_CNT) addr_q <= rx_i[DATA_W-1:0];
      end
      we_q <= v1_q && we_d;
      if (v1_q) begin
        wr_pend_q <= pend_d;
        errfl_q   <= (clr_d ? err_flags_t'('0) : errfl_q) | err_now;
        errsnap_q <= errfl_q;
        src_q     <= src_d;
        ef_q      <= |err_now;
        wdata_q   <= frame_q[DATA_W-1:0];
      end
      // capture after any write has landed
      if (v3_q) resp_q <= {^{ef_q, rsp_data}, ef_q, rsp_data};
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign resp_o      = resp_q;

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  output logic [FRAME_W-3:0] reg_addr_o,
  output logic               reg_we_o,
  output logic [FRAME_W-3:0] reg_wdata_o,
  input  logic [FRAME_W-3:0] reg_rdata_i,
  input  logic               reg_addr_ok_i
);

  localparam int unsigned CNT_W = $clog2(FRAME_W) + 2;

  logic sclk_s, cs_s, mosi_s, sclk_q, cs_q;
  logic sclk_fall, cs_fall, cs_rise, tx_bit;
  logic [FRAME_W-1:0] rx_word, resp_word;
  logic [CNT_W-1:0]   fall_cnt;

  spi_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   ({sclk_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  assign sclk_fall = sclk_q & ~sclk_s;
  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;

  spi_shifter #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (cs_fall),
    .cs_act_i   (~cs_s),
    .sclk_fall_i(sclk_fall),
    .mosi_i     (mosi_s),
    .load_i     (resp_word),
    .rx_o       (rx_word),
    .cnt_o      (fall_cnt),
    .miso_o     (tx_bit)
  );

  spi_reg_ctrl #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_rise_i    (cs_rise),
    .rx_i         (rx_word),
    .cnt_i        (fall_cnt),
    .reg_addr_o   (reg_addr_o),
    .reg_we_o     (reg_we_o),
    .reg_wdata_o  (reg_wdata_o),
    .reg_rdata_i  (reg_rdata_i),
    .reg_addr_ok_i(reg_addr_ok_i),
    .resp_o       (resp_word)
  );

  assign miso_oe_o = ~cs_s;
  assign miso_o    = miso_oe_o & tx_bit;

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int unsigned FRAME_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_ni,
  input logic               miso_oe_o,
  input logic               reg_we_o,
  input logic [FRAME_W-3:0] reg_addr_o,
  input logic [FRAME_W-1:0] resp_i
);

  // R5
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R5
  we_ext_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_addr_o > (FRAME_W-2)'(1)));

  // R2
  we_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !miso_oe_o);

  // R2
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !miso_oe_o);

  // R11
  resp_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(^resp_i));

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_oe_o (miso_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o),
  .resp_i    (u_ctrl.resp_q)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, cs_ni = 1'b1, mosi_i = 1'b0;
  logic miso_o, miso_oe_o, reg_we_o, reg_addr_ok_i;
  logic [13:0] reg_addr_o, reg_wdata_o, reg_rdata_i;

  int checks = 0, fails = 0;
  int wr_cnt = 0;
  logic [13:0] last_addr = '0, last_data = '0;
  logic [13:0] mem [0:15];
  logic [13:0] off;

  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];
  string       tag_q[$];
  event        got_ev;

  always #10 clk_i = ~clk_i;

  spi_reg_slave u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .reg_addr_o(reg_addr_o), .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i), .reg_addr_ok_i(reg_addr_ok_i)
  );

  // register file model: addresses 2..17 exist
  assign off           = reg_addr_o - 14'd2;
  assign reg_addr_ok_i = (reg_addr_o >= 14'd2) && (reg_addr_o < 14'd18);
  assign reg_rdata_i   = reg_addr_ok_i ? mem[off[3:0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 16; k++) mem[k] <= 14'h0100 + 14'(k);
    end else if (reg_we_o && reg_addr_ok_i) begin
      mem[off[3:0]] <= reg_wdata_o;
    end
  end

  always @(posedge clk_i) begin
    if (rst_ni && reg_we_o) begin
      wr_cnt    <= wr_cnt + 1;
      last_addr <= reg_addr_o;
      last_data <= reg_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd(input logic rd, input logic [13:0] a);
    return {^{rd, a}, rd, a};
  endfunction

  function automatic logic [15:0] dat(input logic [13:0] d);
    return {^d, 1'b0, d};
  endfunction

  function automatic logic [15:0] rsp(input logic ef, input logic [13:0] d);
    return {^{ef, d}, ef, d};
  endfunction

  task automatic xfer(input logic [15:0] w, input int nbits, input logic [15:0] exp,
                      input string tag, input bit cmp);
    logic [15:0] r = '0;
    if (cmp) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk_i);
    chk(miso_oe_o == 1'b0, "R2", {15'd0, miso_oe_o}, 16'd0);
    cs_ni = 1'b0;
    repeat (6) @(negedge clk_i);
    for (int i = 0; i < nbits; i++) begin
      sclk_i = 1'b1;
      mosi_i = w[15-i];
      repeat (5) @(negedge clk_i);
      r[15-i] = miso_o;
      if (i == 0) chk(miso_oe_o == 1'b1, "R2", {15'd0, miso_oe_o}, 16'd1);
      sclk_i = 1'b0;
      repeat (5) @(negedge clk_i);
    end
    repeat (3) @(negedge clk_i);
    cs_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    if (cmp) begin
      got_q.push_back(r);
      ->got_ev;
    end
  endtask

  // monitor: compare each received response against the scoreboard
  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() > 0) begin
        logic [15:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
        chk(^g == 1'b0, "R11", g, {^g, g[14:0]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R1
    chk(miso_oe_o == 1'b0, "R1", {15'd0, miso_oe_o}, 16'd0);
    chk(reg_we_o == 1'b0, "R1", {15'd0, reg_we_o}, 16'd0);

    xfer(cmd(1, 14'd5), 16, rsp(0, 14'h0000), "R1", 1);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h0103), "R3", 1);
    xfer(cmd(1, 14'd2), 16, rsp(0, 14'h0000), "R4", 1);
    xfer(cmd(0, 14'd4), 16, rsp(0, 14'h0100), "R3", 1);
    xfer(dat(14'h1ABC), 16, rsp(0, 14'h0102), "R5", 1);
    // R5: one strobe with saved address and data
    chk(wr_cnt == 1, "R5", 16'(wr_cnt), 16'd1);
    chk(last_addr == 14'd4, "R5", {2'b0, last_addr}, 16'd4);
    chk(last_data == 14'h1ABC, "R5", {2'b0, last_data}, 16'h1ABC);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h1ABC), "R5", 1);
    xfer(cmd(1, 14'd6) ^ 16'h8000, 16, rsp(0, 14'h0000), "R4", 1);
    xfer(cmd(1, 14'd1), 16, rsp(1, 14'h0000), "R6", 1);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h0004), "R6", 1);
    xfer(cmd(1, 14'd1), 16, rsp(0, 14'h0000), "R4", 1);
    xfer(cmd(1, 14'h0100), 16, rsp(0, 14'h0000), "R9", 1);
    xfer(cmd(1, 14'd1), 16, rsp(1, 14'h0000), "R7", 1);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h0002), "R7", 1);
    xfer(cmd(1, 14'd5), 8, 16'h0000, "", 0);
    xfer(cmd(1, 14'd1), 16, rsp(1, 14'h0000), "R8", 1);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h0001), "R8", 1);
    xfer(cmd(0, 14'd3), 16, rsp(0, 14'h0000), "R4", 1);
    xfer({^{1'b1, 14'h0555}, 1'b1, 14'h0555}, 16, rsp(0, 14'h0101), "R5", 1);
    xfer(cmd(1, 14'd3), 16, rsp(1, 14'h0000), "R10", 1);
    // R10: bit-14 data frame wrote nothing
    chk(wr_cnt == 1, "R10", 16'(wr_cnt), 16'd1);
    xfer(cmd(1, 14'd1), 16, rsp(0, 14'h0101), "R10", 1);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h0004), "R10", 1);
    xfer(cmd(0, 14'd3), 16, rsp(0, 14'h0000), "R4", 1);
    xfer(dat(14'h0777) ^ 16'h8000, 16, rsp(0, 14'h0101), "R5", 1);
    xfer(cmd(1, 14'd1), 16, rsp(1, 14'h0000), "R10", 1);
    chk(wr_cnt == 1, "R10", 16'(wr_cnt), 16'd1);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h0004), "R10", 1);
    xfer(cmd(1, 14'd0), 16, rsp(0, 14'h0000), "R9", 1);

    repeat (10) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule